// File: doc/BRIEF.md
# Half-Band Low-Pass FIR Filter

This block is a streaming low-pass filter of eleven taps with a fixed, even-symmetric half-band response. It takes 16-bit signed samples qualified by a valid strobe and returns 16-bit signed filtered samples with their own valid strobe. Past inputs sit in a tapped delay line that moves forward only when a new sample is accepted. The coefficients are Q15 constants: a real weight c is held as round(c × 32768). Counting outward from the centre tap at distance 0, the weights are 16384 (0.5) at distance 0, 10285 at distance 1, −3060 (0xF40C) at distance 3 and 1445 at distance 5. Distances 2 and 4 have zero weight.

The structure is built around this coefficient set. Samples that meet the same coefficient are added together before the multiply, so only three constant multipliers remain. Zero-weight taps are never built. The centre weight of one half is taken as the sample aligned to bit 15 and then shifted right by one bit. A wide accumulator sums the terms. The sum is rounded by adding 2^14 and shifting right by 15, then clamped to the 16-bit signed range. A small control unit moves a valid token through the four register stages and enables each stage only when the token reaches it.

Top module: `halfband_fir`

## Requirements
- R1: A synchronous reset clears the delay line, the pipeline registers and `outValid`. During reset and on the cycle after it, `outValid` is 0 and `outData` is 0. After reset, no sample taken before reset contributes to any output.
- R2: For each accepted sample the output is y = Σ h[k]·x[n−k] over k = 0…10, with h = 1445, 0, −3060, 0, 10285, 16384, 10285, 0, −3060, 0, 1445 and k = 0 the newest sample. A lone impulse followed by zeros therefore gives the scaled weights in this order.
- R3: Rounding is round-half-up: the output is floor((acc + 16384) / 32768). An impulse of +1 therefore gives 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, and an impulse of −1 gives all zeros.
- R4: A rounded result above 32767 outputs 32767, and one below −32768 outputs −32768.
- R5: Cycles with `inValid` low do not move the delay line and do not change `outData`. Whatever is on `inData` during those cycles has no effect on any later output.
- R6: The fixed latency is 4 cycles. A sample taken with `inValid` high in cycle t produces `outValid` high in cycle t+4.
- R7: A constant input of +16384 settles, from the eleventh sample on, to 16862, which is 16384 × 33724 / 32768.
- R8: Each accepted sample produces exactly one output strobe. No strobe appears without an accepted sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Marks `inData` as a new sample this cycle |
| inData | input | 16 | Signed two's-complement input sample |
| outValid | output | 1 | Marks `outData` as a new filtered sample |
| outData | output | 16 | Signed two's-complement filtered sample |

## Verification
The hardest case to reach is a valid strobe that stalls and then resumes while samples are still in flight. Gaps must freeze the delay line, and the later stage registers must still deliver the samples already in the pipeline. The stimulus reaches this with a pseudo-random sweep. It inserts idle cycles of random length, drives junk on the data input during those cycles, and in places sends samples back to back, all against a bench-side convolution model. Saturation at both rails needs constant inputs near full scale for at least eleven samples. Rounding at exactly one half needs tiny impulses, where only the centre term is non-zero.

// File: rtl/halfband_fir_pkg.sv
package halfband_fir_pkg;

  localparam int DATA_W       = 16;
  localparam int COEF_W       = 16;
  localparam int COEF_FRAC    = 15;
  localparam int NUM_TAPS     = 11;
  localparam int CENTRE       = (NUM_TAPS - 1) / 2;
  localparam int NUM_PAIRS    = CENTRE;
  localparam int PAIR_W       = DATA_W + 1;
  localparam int ACC_W        = PAIR_W + COEF_W + 3;
  localparam int PIPE_LATENCY = 4;

  // Stage enables issued by the control unit
  typedef struct packed {
    logic advance;
    logic preEn;
    logic mulEn;
    logic sumEn;
  } stageCtl_t;

  // Weight of the taps at distance d from the centre (Q15)
  function automatic int weightAt(int d);
    case (d)
      0: weightAt = 16384;
      1: weightAt = 10285;
      3: weightAt = -3060;
      5: weightAt = 1445;
      default: weightAt = 0;
    endcase
  endfunction

  // Weight of pair k (k = 0 is the outermost pair)
  function automatic int pairWeight(int k);
    pairWeight = weightAt(CENTRE - k);
  endfunction

endpackage

// File: rtl/halfband_fir_ctrl.sv
module halfband_fir_ctrl
  import halfband_fir_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  output stageCtl_t ctl,
  output logic      outValid
);

  logic [PIPE_LATENCY-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[PIPE_LATENCY-2:0], inValid};
    end
  end

  always_comb begin
    ctl.advance = inValid & ~rst;
    ctl.preEn   = validPipe[0];
    ctl.mulEn   = validPipe[1];
    ctl.sumEn   = validPipe[2];
  end

  assign outValid = validPipe[PIPE_LATENCY-1];

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ##4 outValid); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !outValid); // R1

  AST_ONE_STROBE_PER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (!inValid && !validPipe[0]) |=> ##2 !outValid); // R8

endmodule

// File: rtl/halfband_fir_datapath.sv
module halfband_fir_datapath
  import halfband_fir_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  stageCtl_t                ctl,
  input  logic signed [DATA_W-1:0] inData,
  output logic signed [DATA_W-1:0] outData
);

  localparam logic signed [ACC_W-1:0]  ROUND_BIAS = ACC_W'(1) <<< (COEF_FRAC - 1);
  localparam logic signed [ACC_W-1:0]  SAT_MAX    = ACC_W'(32767);
  localparam logic signed [ACC_W-1:0]  SAT_MIN    = -ACC_W'(32768);
  localparam logic signed [DATA_W-1:0] OUT_MAX    = DATA_W'(32767);
  localparam logic signed [DATA_W-1:0] OUT_MIN    = DATA_W'(32768);
  localparam int                       EXT_W      = ACC_W - DATA_W - COEF_FRAC;

  // Tapped delay line, index 0 newest
  logic signed [DATA_W-1:0] taps [NUM_TAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_TAPS; i++) taps[i] <= '0;
    end else if (ctl.advance) begin
      taps[0] <= inData;
      for (int i = 1; i < NUM_TAPS; i++) taps[i] <= taps[i-1];
    end
  end

  // Symmetric pairs: pre-add then constant multiply, zero pairs omitted
  logic signed [ACC_W-1:0] pairProd [NUM_PAIRS];

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : gPair
    localparam int PW = pairWeight(k);
    if (PW != 0) begin : gMul
      localparam logic signed [ACC_W-1:0] WEIGHT = ACC_W'(PW);
      logic signed [PAIR_W-1:0] preSum;
      logic signed [ACC_W-1:0]  preExt;
      logic signed [ACC_W-1:0]  prodReg;

      always_ff @(posedge clk) begin
        if (rst) begin
          preSum <= '0;
        end else if (ctl.preEn) begin
          preSum <= {taps[k][DATA_W-1], taps[k]}
                  + {taps[NUM_TAPS-1-k][DATA_W-1], taps[NUM_TAPS-1-k]};
        end
      end

      assign preExt = ACC_W'(preSum);

      always_ff @(posedge clk) begin
        if (rst) begin
          prodReg <= '0;
        end else if (ctl.mulEn) begin
          prodReg <= preExt * WEIGHT;
        end
      end

      assign pairProd[k] = prodReg;
    end else begin : gZero
      assign pairProd[k] = '0;
    end
  end

  // Centre tap of one half: align to Q15 then shift right by one
  logic signed [DATA_W-1:0] centreReg;
  logic signed [ACC_W-1:0]  centreAligned;
  logic signed [ACC_W-1:0]  centreProd;

  always_ff @(posedge clk) begin
    if (rst) begin
      centreReg <= '0;
    end else if (ctl.preEn) begin
      centreReg <= taps[CENTRE];
    end
  end

  assign centreAligned = {{EXT_W{centreReg[DATA_W-1]}}, centreReg, {COEF_FRAC{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      centreProd <= '0;
    end else if (ctl.mulEn) begin
      centreProd <= centreAligned >>> 1;
    end
  end

  // Accumulate, round half up, saturate
  logic signed [ACC_W-1:0] accSum;
  logic signed [ACC_W-1:0] accBiased;
  logic signed [ACC_W-1:0] accScaled;
  logic signed [DATA_W-1:0] satValue;

  always_comb begin
    accSum = centreProd;
    for (int k = 0; k < NUM_PAIRS; k++) accSum = accSum + pairProd[k];
  end

  assign accBiased = accSum + ROUND_BIAS;
  assign accScaled = accBiased >>> COEF_FRAC;

  always_comb begin
    if (accScaled > SAT_MAX)      satValue = OUT_MAX;
    else if (accScaled < SAT_MIN) satValue = OUT_MIN;
    else                          satValue = accScaled[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData <= '0;
    end else if (ctl.sumEn) begin
      outData <= satValue;
    end
  end

  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ctl.sumEn && accScaled > SAT_MAX) |=> (outData == OUT_MAX)); // R4

  AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (rst)
    (ctl.sumEn && accScaled < SAT_MIN) |=> (outData == OUT_MIN)); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctl.sumEn |=> $stable(outData)); // R5

  AST_LINE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !ctl.advance |=> $stable(taps[0]) && $stable(taps[NUM_TAPS-1])); // R5

endmodule

// File: rtl/halfband_fir.sv
module halfband_fir
  import halfband_fir_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  stageCtl_t                ctl;
  logic signed [DATA_W-1:0] filtered;

  halfband_fir_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .ctl      (ctl),
    .outValid (outValid)
  );

  halfband_fir_datapath uData (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .inData  ($signed(inData)),
    .outData (filtered)
  );

  assign outData = filtered;

endmodule

// File: tb/halfband_fir_test.sv
`timescale 1ns/1ps
module halfband_fir_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [15:0] inData = '0;
  logic        outValid;
  logic [15:0] outData;

  halfband_fir uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycle  = 0;
  int inCount = 0;
  int outCount = 0;
  int lastOut = 0;
  int cf [11] = '{1445, 0, -3060, 0, 10285, 16384, 10285, 0, -3060, 0, 1445};
  int hist [11];
  int expQ [$];
  int cycQ [$];
  string tagQ [$];
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int refOut();
    longint acc = 0;
    longint r;
    for (int k = 0; k < 11; k++) acc += longint'(cf[k]) * longint'(hist[k]);
    r = (acc + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  // Output monitor, samples away from the active edge
  always @(negedge clk) begin
    if (!rst && outValid) begin
      outCount++;
      lastOut = int'($signed(outData));
      if (expQ.size() == 0) begin
        check("R8 unexpected strobe", 1, 0);
      end else begin
        check({tagQ[0], " data"}, lastOut, expQ[0]);
        check("R6 latency", cycle - cycQ[0], 4);
        void'(expQ.pop_front());
        void'(cycQ.pop_front());
        void'(tagQ.pop_front());
      end
    end
  end

  task automatic sendSample(int v, string tag);
    @(negedge clk); #1;
    inValid = 1'b1;
    inData  = 16'(v);
    for (int k = 10; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = v;
    expQ.push_back(refOut());
    cycQ.push_back(cycle);
    tagQ.push_back(tag);
    inCount++;
    @(negedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      inValid = 1'b0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      inData = lfsr;
    end
  endtask

  task automatic sendBurst(int v, int n, string tag);
    @(negedge clk); #1;
    for (int i = 0; i < n; i++) begin
      inValid = 1'b1;
      inData  = 16'(v);
      for (int k = 10; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = v;
      expQ.push_back(refOut());
      cycQ.push_back(cycle);
      tagQ.push_back(tag);
      inCount++;
      @(negedge clk); #1;
    end
    inValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); #1;
    rst = 1'b1;
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 outValid in reset", int'(outValid), 0);
    check("R1 outData in reset", int'($signed(outData)), 0);
    expQ.delete(); cycQ.delete(); tagQ.delete();
    for (int k = 0; k < 11; k++) hist[k] = 0;
    inCount = 0; outCount = 0;
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 outValid after reset", int'(outValid), 0);
    check("R1 outData after reset", int'($signed(outData)), 0);
  endtask

  task automatic drain();
    idle(8);
    check("R8 drained queue", expQ.size(), 0);
    check("R8 strobe count", outCount, inCount);
  endtask

  initial begin
    for (int k = 0; k < 11; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    doReset();

    // R2 impulse at full positive and full negative scale
    sendSample(32767, "R2 impulse+");
    for (int i = 0; i < 12; i++) sendSample(0, "R2 impulse+");
    drain();
    sendSample(-32768, "R2 impulse-");
    for (int i = 0; i < 12; i++) sendSample(0, "R2 impulse-");
    drain();

    // R3 rounding of exact halves
    sendSample(1, "R3 unit+");
    for (int i = 0; i < 11; i++) sendSample(0, "R3 unit+");
    sendSample(-1, "R3 unit-");
    for (int i = 0; i < 11; i++) sendSample(0, "R3 unit-");
    sendSample(3, "R3 three");
    for (int i = 0; i < 11; i++) sendSample(0, "R3 three");
    drain();

    // R7 DC settle, back to back
    sendBurst(16384, 16, "R7 dc");
    drain();
    check("R7 dc settled", lastOut, 16862);

    // R4 saturation at both rails
    sendBurst(32767, 14, "R4 sat high");
    drain();
    check("R4 high rail", lastOut, 32767);
    sendBurst(-32768, 14, "R4 sat low");
    drain();
    check("R4 low rail", lastOut, -32768);

    // R5 sweep with random gaps and junk data
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sendSample(int'($signed(lfsr)), "R5 gapped sweep");
      idle(int'(lfsr[1:0]));
    end
    drain();

    // R1 reset mid-stream then clean impulse
    sendBurst(-20000, 6, "R1 pre");
    doReset();
    idle(6);
    check("R1 no stale strobe", outCount, 0);
    sendSample(20000, "R1 clean impulse");
    for (int i = 0; i < 11; i++) sendSample(0, "R1 clean impulse");
    drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #900000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule